// File: doc/BRIEF.md
# Serial Bus Peripheral Interrupt Vector Controller

This block turns the status flags of a two-wire serial bus engine into a single prioritised interrupt request with an 8-bit vector. It sorts the engine's flags into three sources: an error/event source, a data-received source and a ready-to-transmit source. Each source has a pending bit that hardware sets and software clears, and a mask bit. A global enable, a 3-bit priority level compared with the CPU's current level, and a DMA-busy input decide whether the request line is raised.

The vector is built from five software bits on top and a three-bit source code below. When several masked sources are pending, the code of the most urgent one is used: error first, then data received, then ready to transmit. When DMA handles a direction, the normal byte event for that direction no longer sets its pending bit. The DMA end-of-block event sets it instead and reuses that source's vector. A control bit lets a pending error hold DMA transfers.

Top module: `twb_irq_top`

## Requirements
- R1: After reset all three pending bits are 0, `irqReq` is 0, `eventFlag` is 0 and `dmaSuspend` is 0.
- R2: The error pending bit is set at the clock edge where `evtFlag` is 1 and at least one of these is 1: `startSent`, `ackFail`, `stopSeen`, `arbLost`, `busErr`, `hdrSent`, `addrSent`, or (`addrMatch` and `ackEn`). If `evtFlag` is 0, none of them sets it, and `addrMatch` without `ackEn` does not set it.
- R3: When DMA is off for that direction, `byteDone`=1 with `xmitMode`=0 sets the receive pending bit, and `byteDone`=1 with `xmitMode`=1 sets the transmit pending bit.
- R4: With `dmaRxEn`=1, the byte event no longer sets the receive pending bit and `dmaRxEob` sets it instead. `dmaTxEn` and `dmaTxEob` act the same way on the transmit bit. An end-of-block input has no effect while its enable is 0.
- R5: A pending bit stays set until its clear strobe (`clrErr`, `clrRx`, `clrTx`) is 1 at a clock edge. If a set event and a clear strobe happen in the same cycle, the bit ends up set.
- R6: `irqReq` is 1 only when some pending bit has its mask set, `globalEn` is 1, `prioLevel` < `cpuLevel` (unsigned) and `dmaBusy` is 0. Because of this, `prioLevel`=3'b111 never raises a request.
- R7: `irqVector` = {`vecBase`, code}. The code is 3'b010 for error, 3'b100 for data received and 3'b110 for ready to transmit. It belongs to the highest-ranked source that is both pending and masked in (error > received > transmit), and is 3'b000 when there is none.
- R8: `dmaSuspend` is 1 exactly while `errHoldsDma` is 1 and the error pending bit is set.
- R9: `eventFlag` is 1 for the cycle after each clock edge that sets a pending bit from a non-end-of-block condition (R2 or R3). End-of-block events leave it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtFlag | input | 1 | Engine event flag qualifying error causes |
| byteDone | input | 1 | Byte transfer finished |
| xmitMode | input | 1 | Engine is transmitter |
| addrMatch | input | 1 | Slave address matched |
| ackEn | input | 1 | Acknowledge enabled |
| startSent | input | 1 | Start condition generated |
| ackFail | input | 1 | No acknowledge after a byte |
| stopSeen | input | 1 | Stop detected as slave |
| arbLost | input | 1 | Arbitration lost as master |
| busErr | input | 1 | Misplaced start/stop on the bus |
| hdrSent | input | 1 | 10-bit header byte sent |
| addrSent | input | 1 | Address byte sent as master |
| dmaRxEn | input | 1 | DMA handles receive |
| dmaTxEn | input | 1 | DMA handles transmit |
| dmaRxEob | input | 1 | Receive end-of-block event |
| dmaTxEob | input | 1 | Transmit end-of-block event |
| dmaBusy | input | 1 | DMA activity, blocks requests |
| globalEn | input | 1 | Global interrupt enable |
| maskErr | input | 1 | Error source mask |
| maskRx | input | 1 | Receive source mask |
| maskTx | input | 1 | Transmit source mask |
| clrErr | input | 1 | Clear strobe, error pending |
| clrRx | input | 1 | Clear strobe, receive pending |
| clrTx | input | 1 | Clear strobe, transmit pending |
| errHoldsDma | input | 1 | Pending error suspends DMA |
| prioLevel | input | 3 | Block priority, 0 highest |
| cpuLevel | input | 3 | Current CPU priority |
| vecBase | input | 5 | Software part of vector |
| irqReq | output | 1 | Interrupt request |
| irqVector | output | 8 | Interrupt vector |
| eventFlag | output | 1 | Non-end-of-block event pulse |
| dmaSuspend | output | 1 | Hold DMA transfers |

## Verification
The hardest situation to reach is three pending bits that were set by different paths and are then read one at a time, because the pending state has no port of its own. The bench sets one stimulus pattern per table row, from status flags or from DMA end-of-block events. It then reads each pending bit back by opening one mask at a time and watching `irqReq`, with the vector and priority conditions held so that they allow a request. The same readout, done after a set and a clear in the same cycle, shows that the set wins.

// File: rtl/twb_irq_pkg.sv
package twb_irq_pkg;
  localparam int SRC_N   = 3;
  localparam int CODE_W  = 3;
  localparam int VEC_W   = 8;
  localparam int BASE_W  = VEC_W - CODE_W;
  localparam int PRIO_W  = 3;
  localparam int ERR_IDX = 2;
  localparam int RX_IDX  = 1;
  localparam int TX_IDX  = 0;

  typedef struct packed {
    logic errSet;
    logic rxSet;
    logic txSet;
    logic flagEvt;
  } setStrobes_t;
endpackage

// File: rtl/twb_irq_ctl.sv
module twb_irq_ctl
  import twb_irq_pkg::*;
(
  input  logic        evtFlag,
  input  logic        byteDone,
  input  logic        xmitMode,
  input  logic        addrMatch,
  input  logic        ackEn,
  input  logic        startSent,
  input  logic        ackFail,
  input  logic        stopSeen,
  input  logic        arbLost,
  input  logic        busErr,
  input  logic        hdrSent,
  input  logic        addrSent,
  input  logic        dmaRxEn,
  input  logic        dmaTxEn,
  input  logic        dmaRxEob,
  input  logic        dmaTxEob,
  output setStrobes_t strobes
);
  logic errCause;
  logic rxByte;
  logic txByte;
  logic rxNorm;
  logic txNorm;

  // R2: error source collects the qualified engine events
  assign errCause = (addrMatch & ackEn) | startSent | ackFail | stopSeen |
                    arbLost | busErr | hdrSent | addrSent;

  // R3: byte events split by transfer direction
  assign rxByte = byteDone & ~xmitMode;
  assign txByte = byteDone &  xmitMode;

  // R4: DMA ownership of a direction removes the byte event
  assign rxNorm = rxByte & ~dmaRxEn;
  assign txNorm = txByte & ~dmaTxEn;

  always_comb begin
    strobes.errSet  = evtFlag & errCause;
    strobes.rxSet   = rxNorm | (dmaRxEn & dmaRxEob);
    strobes.txSet   = txNorm | (dmaTxEn & dmaTxEob);
    strobes.flagEvt = (evtFlag & errCause) | rxNorm | txNorm;  // R9
  end
endmodule

// File: rtl/twb_irq_dp.sv
module twb_irq_dp
  import twb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  setStrobes_t       strobes,
  input  logic [SRC_N-1:0]  clrVec,
  input  logic [SRC_N-1:0]  maskVec,
  input  logic              globalEn,
  input  logic [PRIO_W-1:0] prioLevel,
  input  logic [PRIO_W-1:0] cpuLevel,
  input  logic              dmaBusy,
  input  logic [BASE_W-1:0] vecBase,
  input  logic              errHoldsDma,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector,
  output logic              eventFlag,
  output logic              dmaSuspend,
  output logic [SRC_N-1:0]  pendBits
);
  logic [SRC_N-1:0]  setVec;
  logic [SRC_N-1:0]  activeVec;
  logic [CODE_W-1:0] selCode;
  logic              prioOk;

  assign setVec = {strobes.errSet, strobes.rxSet, strobes.txSet};

  // R5: per-source pending bit, set beats clear
  for (genvar i = 0; i < SRC_N; i++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendBits[i] <= 1'b0;
      else       pendBits[i] <= (pendBits[i] & ~clrVec[i]) | setVec[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eventFlag <= 1'b0;
    else       eventFlag <= strobes.flagEvt;
  end

  assign activeVec = pendBits & maskVec;

  // R7: higher index ranks higher; code = 2*(SRC_N-index)
  always_comb begin
    selCode = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (activeVec[i]) selCode = CODE_W'((SRC_N - i) * 2);
    end
  end

  // R6: lower value is more urgent; 3'b111 can never be below cpuLevel
  assign prioOk     = prioLevel < cpuLevel;
  assign irqReq     = globalEn & (|activeVec) & prioOk & ~dmaBusy;
  assign irqVector  = {vecBase, selCode};
  assign dmaSuspend = errHoldsDma & pendBits[ERR_IDX];  // R8
endmodule

// File: rtl/twb_irq_top.sv
module twb_irq_top
  import twb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtFlag,
  input  logic              byteDone,
  input  logic              xmitMode,
  input  logic              addrMatch,
  input  logic              ackEn,
  input  logic              startSent,
  input  logic              ackFail,
  input  logic              stopSeen,
  input  logic              arbLost,
  input  logic              busErr,
  input  logic              hdrSent,
  input  logic              addrSent,
  input  logic              dmaRxEn,
  input  logic              dmaTxEn,
  input  logic              dmaRxEob,
  input  logic              dmaTxEob,
  input  logic              dmaBusy,
  input  logic              globalEn,
  input  logic              maskErr,
  input  logic              maskRx,
  input  logic              maskTx,
  input  logic              clrErr,
  input  logic              clrRx,
  input  logic              clrTx,
  input  logic              errHoldsDma,
  input  logic [PRIO_W-1:0] prioLevel,
  input  logic [PRIO_W-1:0] cpuLevel,
  input  logic [BASE_W-1:0] vecBase,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector,
  output logic              eventFlag,
  output logic              dmaSuspend
);
  setStrobes_t      strobes;
  logic [SRC_N-1:0] pendBits;

  twb_irq_ctl i_ctl (
    .evtFlag(evtFlag), .byteDone(byteDone), .xmitMode(xmitMode),
    .addrMatch(addrMatch), .ackEn(ackEn), .startSent(startSent),
    .ackFail(ackFail), .stopSeen(stopSeen), .arbLost(arbLost),
    .busErr(busErr), .hdrSent(hdrSent), .addrSent(addrSent),
    .dmaRxEn(dmaRxEn), .dmaTxEn(dmaTxEn), .dmaRxEob(dmaRxEob),
    .dmaTxEob(dmaTxEob), .strobes(strobes)
  );

  twb_irq_dp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .clrVec({clrErr, clrRx, clrTx}),
    .maskVec({maskErr, maskRx, maskTx}),
    .globalEn(globalEn), .prioLevel(prioLevel), .cpuLevel(cpuLevel),
    .dmaBusy(dmaBusy), .vecBase(vecBase), .errHoldsDma(errHoldsDma),
    .irqReq(irqReq), .irqVector(irqVector), .eventFlag(eventFlag),
    .dmaSuspend(dmaSuspend), .pendBits(pendBits)
  );
endmodule

// File: rtl/twb_irq_chk.sv
module twb_irq_chk
  import twb_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic [VEC_W-1:0]  irqVector,
  input logic              globalEn,
  input logic [PRIO_W-1:0] prioLevel,
  input logic [PRIO_W-1:0] cpuLevel,
  input logic              dmaBusy,
  input logic [BASE_W-1:0] vecBase,
  input logic [SRC_N-1:0]  pendBits,
  input logic              maskErr,
  input logic              clrErr,
  input logic              errHoldsDma,
  input logic              dmaSuspend
);
  assert_req_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (globalEn && (prioLevel < cpuLevel) && !dmaBusy));

  assert_lowest_never_R6: assert property (@(posedge clk) disable iff (!rstN)
    (prioLevel == 3'b111) |-> !irqReq);

  assert_vec_base_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector[VEC_W-1:CODE_W] == vecBase));

  assert_err_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits[ERR_IDX] && maskErr) |-> (irqVector[CODE_W-1:0] == 3'b010));

  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits[ERR_IDX] && !clrErr) |=> pendBits[ERR_IDX]);

  assert_suspend_src_R8: assert property (@(posedge clk) disable iff (!rstN)
    dmaSuspend |-> (errHoldsDma && pendBits[ERR_IDX]));
endmodule

bind twb_irq_top twb_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqVector(irqVector),
  .globalEn(globalEn), .prioLevel(prioLevel), .cpuLevel(cpuLevel),
  .dmaBusy(dmaBusy), .vecBase(vecBase), .pendBits(pendBits),
  .maskErr(maskErr), .clrErr(clrErr), .errHoldsDma(errHoldsDma),
  .dmaSuspend(dmaSuspend)
);

// File: tb/test_twb_irq_top.sv
module test_twb_irq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtFlag = 0, byteDone = 0, xmitMode = 0, addrMatch = 0, ackEn = 0;
  logic startSent = 0, ackFail = 0, stopSeen = 0, arbLost = 0, busErr = 0;
  logic hdrSent = 0, addrSent = 0;
  logic dmaRxEn = 0, dmaTxEn = 0, dmaRxEob = 0, dmaTxEob = 0, dmaBusy = 0;
  logic globalEn = 1, maskErr = 0, maskRx = 0, maskTx = 0;
  logic clrErr = 0, clrRx = 0, clrTx = 0, errHoldsDma = 0;
  logic [2:0] prioLevel = 3'd0, cpuLevel = 3'd7;
  logic [4:0] vecBase = 5'b10110;
  logic irqReq, eventFlag, dmaSuspend;
  logic [7:0] irqVector;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  twb_irq_top i_twb_irq_top (.*);

  // flags [11]evtFlag [10]byteDone [9]xmitMode [8]addrMatch [7]ackEn [6]startSent
  //       [5]ackFail [4]stopSeen [3]arbLost [2]busErr [1]hdrSent [0]addrSent
  // dma   [3]rxEn [2]txEn [1]rxEob [0]txEob ; expected pend {err,rx,tx}, eventFlag
  localparam int NV = 18;
  localparam logic [19:0] TBL [NV] = '{
    {12'b1000_0100_0000, 4'b0000, 3'b100, 1'b1},
    {12'b0000_0100_0000, 4'b0000, 3'b000, 1'b0},
    {12'b1001_0000_0000, 4'b0000, 3'b000, 1'b0},
    {12'b1001_1000_0000, 4'b0000, 3'b100, 1'b1},
    {12'b1000_0010_0000, 4'b0000, 3'b100, 1'b1},
    {12'b1000_0001_0000, 4'b0000, 3'b100, 1'b1},
    {12'b1000_0000_1000, 4'b0000, 3'b100, 1'b1},
    {12'b1000_0000_0100, 4'b0000, 3'b100, 1'b1},
    {12'b1000_0000_0010, 4'b0000, 3'b100, 1'b1},
    {12'b1000_0000_0001, 4'b0000, 3'b100, 1'b1},
    {12'b0100_0000_0000, 4'b0000, 3'b010, 1'b1},
    {12'b0110_0000_0000, 4'b0000, 3'b001, 1'b1},
    {12'b0100_0000_0000, 4'b1000, 3'b000, 1'b0},
    {12'b0000_0000_0000, 4'b1010, 3'b010, 1'b0},
    {12'b0000_0000_0000, 4'b0101, 3'b001, 1'b0},
    {12'b0110_0000_0000, 4'b0100, 3'b000, 1'b0},
    {12'b0000_0000_0000, 4'b0011, 3'b000, 1'b0},
    {12'b1100_0000_0100, 4'b0000, 3'b110, 1'b1}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setFlags(logic [11:0] f, logic [3:0] d);
    {evtFlag, byteDone, xmitMode, addrMatch, ackEn, startSent,
     ackFail, stopSeen, arbLost, busErr, hdrSent, addrSent} = f;
    {dmaRxEn, dmaTxEn, dmaRxEob, dmaTxEob} = d;
  endtask

  // reads pending bits through the request line, one mask at a time
  task automatic readPend(output logic [2:0] p);
    {maskErr, maskRx, maskTx} = 3'b100; #1 p[2] = irqReq;
    {maskErr, maskRx, maskTx} = 3'b010; #1 p[1] = irqReq;
    {maskErr, maskRx, maskTx} = 3'b001; #1 p[0] = irqReq;
    {maskErr, maskRx, maskTx} = 3'b000;
  endtask

  task automatic clearAll();
    @(negedge clk); {clrErr, clrRx, clrTx} = 3'b111;
    @(negedge clk); {clrErr, clrRx, clrTx} = 3'b000;
  endtask

  task automatic pulse(logic [11:0] f, logic [3:0] d);
    @(negedge clk); setFlags(f, d);
    @(negedge clk); setFlags('0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] p;
    #12;
    // R1: reset state
    readPend(p);
    chk("R1 pending", {5'd0, p}, 8'd0);
    chk("R1 irqReq", {7'd0, irqReq}, 8'd0);
    chk("R1 eventFlag", {7'd0, eventFlag}, 8'd0);
    chk("R1 dmaSuspend", {7'd0, dmaSuspend}, 8'd0);
    @(negedge clk); rstN = 1;

    // R2 R3 R4 R9: table walk
    for (int k = 0; k < NV; k++) begin
      string tag;
      logic [19:0] e = TBL[k];
      if (e[7:4] != 0) tag = "R4";
      else if (e[18]) tag = "R3";
      else tag = "R2";
      pulse(e[19:8], e[7:4]);
      chk($sformatf("R9 row %0d eventFlag", k), {7'd0, eventFlag}, {7'd0, e[0]});
      readPend(p);
      chk($sformatf("%s row %0d pending", tag, k), {5'd0, p}, {5'd0, e[3:1]});
      clearAll();
    end

    // R7: vector order with all three pending
    pulse(12'b1000_0100_0000, 4'b0000);
    pulse(12'b0100_0000_0000, 4'b0000);
    pulse(12'b0110_0000_0000, 4'b0000);
    {maskErr, maskRx, maskTx} = 3'b111; #1;
    chk("R7 err vector", irqVector, {vecBase, 3'b010});
    {maskErr, maskRx, maskTx} = 3'b011; #1;
    chk("R7 rx vector", irqVector, {vecBase, 3'b100});
    {maskErr, maskRx, maskTx} = 3'b001; #1;
    chk("R7 tx vector", irqVector, {vecBase, 3'b110});
    {maskErr, maskRx, maskTx} = 3'b000; #1;
    chk("R7 none vector", irqVector, {vecBase, 3'b000});
    chk("R6 no mask no req", {7'd0, irqReq}, 8'd0);

    // R6: gating
    maskTx = 1; #1;
    chk("R6 baseline req", {7'd0, irqReq}, 8'd1);
    globalEn = 0; #1;
    chk("R6 globalEn off", {7'd0, irqReq}, 8'd0);
    globalEn = 1; prioLevel = 3'd4; cpuLevel = 3'd4; #1;
    chk("R6 equal level", {7'd0, irqReq}, 8'd0);
    prioLevel = 3'd7; cpuLevel = 3'd7; #1;
    chk("R6 level 7", {7'd0, irqReq}, 8'd0);
    prioLevel = 3'd6; #1;
    chk("R6 level 6 vs 7", {7'd0, irqReq}, 8'd1);
    dmaBusy = 1; #1;
    chk("R6 dmaBusy", {7'd0, irqReq}, 8'd0);
    dmaBusy = 0; prioLevel = 3'd0; maskTx = 0;

    // R8: suspend follows error pending and control bit
    @(negedge clk); errHoldsDma = 1; #1;
    chk("R8 suspend on", {7'd0, dmaSuspend}, 8'd1);
    errHoldsDma = 0; #1;
    chk("R8 suspend off", {7'd0, dmaSuspend}, 8'd0);
    errHoldsDma = 1;

    // R5: single clear, then set against clear
    @(negedge clk); clrErr = 1;
    @(negedge clk); clrErr = 0;
    readPend(p);
    chk("R5 clear err only", {5'd0, p}, 8'b011);
    chk("R8 suspend after clear", {7'd0, dmaSuspend}, 8'd0);
    @(negedge clk); clrErr = 1; setFlags(12'b1000_0000_0100, 4'b0000);
    @(negedge clk); clrErr = 0; setFlags('0, '0);
    readPend(p);
    chk("R5 set wins over clear", {5'd0, p}, 8'b111);
    clearAll();
    readPend(p);
    chk("R5 clear all", {5'd0, p}, 8'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule